// File: doc/BRIEF.md
# Half to Single Precision Float Converter

This block widens a 16-bit half-precision floating-point value into a 32-bit single-precision value. The half is picked out of a 32-bit input word, either its upper or its lower sixteen bits, so a register holding two packed halves can feed either one. Every half-precision value has an exact single-precision image, so the block has no rounding logic. Subnormal halves become single-precision normals, with a combinational leading-zero count setting the shift.

Two control inputs change how special encodings are read. With the alternative-format control set, the all-ones half exponent is an ordinary exponent and the input has no infinities and no NaNs. With the default-NaN control set, any NaN result is replaced by the canonical quiet NaN. A signalling NaN input sets an invalid-operation flag. That flag stays set until software-visible logic pulses a clear input.

The block has a two-state sequencer. It sits in ST_IDLE. The transition GO_EMIT, taken on any cycle with `in_valid` high, moves it to ST_EMIT. In ST_EMIT, `out_valid` is high for one cycle. From ST_EMIT, the transition GO_EMIT is taken again when another input arrives, and otherwise GO_IDLE returns the sequencer to ST_IDLE. The result register loads on every accepted input and keeps its value between inputs.

Top module: `h2s_convert`

## Requirements
- R1: After reset, `out_valid`, `out_single` and `invalid_flag` are all zero.
- R2: When `sel_upper` is 1 the half is `in_word[31:16]`, otherwise it is `in_word[15:0]`. Within the half, the sign is bit 15, the exponent is bits 14:10 and the mantissa is bits 9:0. Single output fields are sign at bit 31, exponent at bits 30:23 and fraction at bits 22:0.
- R3: A half with zero exponent and zero mantissa gives a zero with the same sign (0x00000000 or 0x80000000).
- R4: A half with exponent 1 to 30 gives single exponent = half exponent + 112 and fraction = mantissa shifted left by 13, with the sign kept.
- R5: A half with zero exponent and nonzero mantissa is normalised. Shift the mantissa left by k until bit 10 is set. The single exponent is then 113 - k, and the fraction is the low 10 bits of the shifted mantissa, shifted left by 13.
- R6: Without the alternative format, exponent 31 with zero mantissa gives a signed infinity (0x7F800000 or 0xFF800000).
- R7: Without the alternative format and without default-NaN, exponent 31 with mantissa bit 9 set gives exponent 0xFF. The sign is kept, the fraction is the mantissa shifted left by 13, and the invalid flag is not set.
- R8: Without the alternative format, exponent 31 with a nonzero mantissa whose bit 9 is clear is a signalling NaN. It sets `invalid_flag`. If default-NaN is off, the result is the payload shifted left by 13 with fraction bit 22 forced to 1.
- R9: With default-NaN set and no alternative format, any NaN input gives 0x7FC00000.
- R10: With the alternative format set, exponent 31 converts as a normal value (single exponent 143). `invalid_flag` is never set by such an input.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_single` changes only on those edges.
- R12: `invalid_flag` stays set until `clr_invalid` is sampled high. A signalling NaN accepted in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_word | input | 32 | Word holding two packed halves |
| sel_upper | input | 1 | 1 selects bits 31:16, 0 selects bits 15:0 |
| alt_half | input | 1 | Alternative format: exponent 31 is ordinary |
| default_nan | input | 1 | Replace any NaN result with the canonical quiet NaN |
| clr_invalid | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Result valid strobe, one cycle |
| out_single | output | 32 | Single-precision result, held between inputs |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
If the sequencer is stuck in the wrong state, `out_valid` is wrong in the very next cycle, because the strobe is the state itself. A wrong shift count or a wrong exponent offset in the datapath shows in `out_single` one edge after the input. The bench sweeps every mantissa width for subnormals so that each leading-zero count is exercised. A wrong flag update shows on `invalid_flag` one edge after the signalling input or the clear. Because the flag is sticky, the wrong value then persists until the next clear, where the per-clock comparison keeps catching it.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
    localparam int HALF_W    = 16;
    localparam int HEXP_W    = 5;
    localparam int HMAN_W    = 10;
    localparam int SEXP_W    = 8;
    localparam int SFRAC_W   = 23;
    localparam int SINGLE_W  = 1 + SEXP_W + SFRAC_W;
    localparam int BIAS_DIFF = 112;
    localparam int FRAC_GAP  = SFRAC_W - HMAN_W;
    localparam int LZ_W      = $clog2(HMAN_W + 1);

    typedef struct packed {
        logic              sign;
        logic [HEXP_W-1:0] exp;
        logic [HMAN_W-1:0] man;
    } half_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
    parameter int W   = 10,
    parameter int CNT = $clog2(W + 1)
) (
    input  logic [W-1:0]   vec,
    output logic [CNT-1:0] count
);
    // Scan from LSB upward; the highest set bit writes last and wins.
    always_comb begin
        count = CNT'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) count = CNT'(W - 1 - i);
        end
    end
endmodule

// File: rtl/h2s_unpack.sv
module h2s_unpack
    import h2s_pkg::*;
(
    input  logic [2*HALF_W-1:0] word,
    input  logic                upper,
    output half_t               half
);
    logic [HALF_W-1:0] lanes [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lanes[g] = word[g*HALF_W +: HALF_W];
    end

    assign half = upper ? lanes[1] : lanes[0];
endmodule

// File: rtl/h2s_core.sv
module h2s_core
    import h2s_pkg::*;
(
    input  half_t                half,
    input  logic                 alt_half,
    input  logic                 default_nan,
    output logic [SINGLE_W-1:0]  result,
    output logic                 snan
);
    localparam logic [HEXP_W-1:0] HEXP_MAX = '1;
    localparam logic [SEXP_W-1:0] SEXP_MAX = '1;

    logic [LZ_W-1:0]   lz;
    logic [HMAN_W:0]   shifted;
    logic              r_sign;
    logic [SEXP_W-1:0] r_exp;
    logic [SFRAC_W-1:0] r_frac;

    h2s_lzc #(.W(HMAN_W), .CNT(LZ_W)) u_lzc (
        .vec   (half.man),
        .count (lz)
    );

    assign shifted = {1'b0, half.man} << (lz + LZ_W'(1));

    always_comb begin
        r_sign = half.sign;
        r_exp  = '0;
        r_frac = '0;
        snan   = 1'b0;
        if (half.exp == '0) begin
            if (half.man != '0) begin
                r_exp  = SEXP_W'(BIAS_DIFF) - SEXP_W'(lz);
                r_frac = {shifted[HMAN_W-1:0], {FRAC_GAP{1'b0}}};
            end
        end else if (half.exp == HEXP_MAX && !alt_half) begin
            r_exp = SEXP_MAX;
            if (half.man != '0) begin
                snan = !half.man[HMAN_W-1];
                if (default_nan) begin
                    r_sign = 1'b0;
                    r_frac = {1'b1, {(SFRAC_W-1){1'b0}}};
                end else begin
                    r_frac = {1'b1, half.man[HMAN_W-2:0], {FRAC_GAP{1'b0}}};
                end
            end
        end else begin
            r_exp  = SEXP_W'(half.exp) + SEXP_W'(BIAS_DIFF);
            r_frac = {half.man, {FRAC_GAP{1'b0}}};
        end
    end

    assign result = {r_sign, r_exp, r_frac};

    // R10
    always_comb begin
        ahp_no_special_chk: assert (!(alt_half && (result[SINGLE_W-2 -: SEXP_W] == SEXP_MAX)));
    end
endmodule

// File: rtl/h2s_convert.sv
module h2s_convert
    import h2s_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    input  logic        sel_upper,
    input  logic        alt_half,
    input  logic        default_nan,
    input  logic        clr_invalid,
    output logic        out_valid,
    output logic [31:0] out_single,
    output logic        invalid_flag
);
    seq_state_t        state_q, state_d;
    half_t             half;
    logic [SINGLE_W-1:0] conv;
    logic              snan;
    logic [SINGLE_W-1:0] result_q;
    logic              inv_q;

    h2s_unpack u_unpack (
        .word  (in_word),
        .upper (sel_upper),
        .half  (half)
    );

    h2s_core u_core (
        .half        (half),
        .alt_half    (alt_half),
        .default_nan (default_nan),
        .result      (conv),
        .snan        (snan)
    );

    // Next-state: GO_EMIT on an accepted input, GO_IDLE otherwise.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            inv_q    <= 1'b0;
        end else begin
            if (in_valid) result_q <= conv;
            if (in_valid && snan) inv_q <= 1'b1;
            else if (clr_invalid) inv_q <= 1'b0;
        end
    end

    assign out_valid    = (state_q == ST_EMIT);
    assign out_single   = result_q;
    assign invalid_flag = inv_q;

    // R11
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_single));
    // R12
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_flag && !clr_invalid) |=> invalid_flag);
    // R12
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_invalid && !in_valid) |=> !invalid_flag);
endmodule

// File: tb/tb_h2s_convert.sv
module tb_h2s_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        sel_upper = 1'b0;
    logic        alt_half = 1'b0;
    logic        default_nan = 1'b0;
    logic        clr_invalid = 1'b0;
    logic        out_valid;
    logic [31:0] out_single;
    logic        invalid_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic        m_valid = 1'b0;
    logic [31:0] m_out = '0;
    logic        m_inv = 1'b0;
    string       m_tag = "R1";

    always #2 clk = ~clk;

    h2s_convert dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .sel_upper(sel_upper), .alt_half(alt_half), .default_nan(default_nan),
        .clr_invalid(clr_invalid), .out_valid(out_valid),
        .out_single(out_single), .invalid_flag(invalid_flag)
    );

    function automatic logic [31:0] ref_conv(input logic [31:0] w, input bit up,
                                             input bit ahp, input bit dn,
                                             output bit sig, output string tag);
        logic [15:0] h;
        int s, e, m, ex;
        h = up ? w[31:16] : w[15:0];
        s = h[15]; e = h[14:10]; m = h[9:0];
        sig = 0;
        if (ahp && e == 31) begin
            tag = "R10";
            return {s[0], 8'(e + 112), 10'(m), 13'd0};
        end
        if (e == 31 && m == 0) begin tag = "R6"; return {s[0], 8'hFF, 23'd0}; end
        if (e == 31) begin
            sig = (m < 512);
            if (dn) begin tag = "R9"; return 32'h7FC00000; end
            tag = sig ? "R8" : "R7";
            return {s[0], 8'hFF, 10'(m | 512), 13'd0};
        end
        if (e == 0 && m == 0) begin tag = "R3"; return {s[0], 31'd0}; end
        if (e == 0) begin
            ex = 113;
            while (m < 1024) begin m = m * 2; ex = ex - 1; end
            tag = "R5";
            return {s[0], 8'(ex), 10'(m % 1024), 13'd0};
        end
        tag = "R4";
        return {s[0], 8'(e + 112), 10'(m), 13'd0};
    endfunction

    // Behavioural reference, one register stage like the ports require.
    always @(posedge clk) begin
        bit sig;
        string t;
        logic [31:0] r;
        if (!rst_n) begin
            m_valid <= 1'b0; m_out <= '0; m_inv <= 1'b0;
        end else begin
            r = ref_conv(in_word, sel_upper, alt_half, default_nan, sig, t);
            m_valid <= in_valid;
            if (in_valid) begin
                m_out <= r;
                // R2: upper lane cases are tagged too
                m_tag <= sel_upper ? {"R2/", t} : t;
            end
            if (in_valid && sig) m_inv <= 1'b1;
            else if (clr_invalid) m_inv <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk("R11 out_valid", {31'd0, out_valid}, {31'd0, m_valid});
            chk(m_tag, out_single, m_out);
            chk("R12/R8 invalid_flag", {31'd0, invalid_flag}, {31'd0, m_inv});
        end
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic send(input logic [31:0] w, input bit up, input bit ahp,
                        input bit dn, input bit clr);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; sel_upper = up;
        alt_half = ahp; default_nan = dn; clr_invalid = clr;
    endtask

    task automatic idle(input int n, input bit clr);
        @(negedge clk);
        in_valid = 1'b0; clr_invalid = clr; in_word = 32'hDEADBEEF;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            clr_invalid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 out_single", out_single, 32'd0);
        chk("R1 invalid_flag", {31'd0, invalid_flag}, 32'd0);
        rst_n = 1'b1;
        send(32'h12343C00, 0, 0, 0, 0);   // R4 1.0
        send(32'h4000ABCD, 1, 0, 0, 0);   // R2 upper lane
        send(32'h00008000, 0, 0, 0, 0);   // R3 negative zero
        send(32'h80000000, 1, 0, 0, 0);   // R3 upper
        send(32'h00000001, 0, 0, 0, 0);   // R5 smallest
        send(32'h000083FF, 0, 0, 0, 0);   // R5 largest
        idle(2, 0);
        send(32'h00007C00, 0, 0, 0, 0);   // R6
        send(32'hFC000000, 1, 0, 0, 0);   // R6 negative
        send(32'h0000FE05, 0, 0, 0, 0);   // R7 quiet
        idle(2, 0);
        send(32'h00007C01, 0, 0, 0, 0);   // R8 signalling
        idle(3, 0);                        // R12 sticky
        idle(2, 1);                        // R12 clear
        send(32'h0000FE00, 0, 0, 1, 0);   // R9 quiet with DN
        send(32'h0000FD00, 0, 0, 1, 0);   // R9 signalling with DN
        send(32'h00007C00, 0, 1, 0, 1);   // R10 AHP, clear
        send(32'hFFFF0000, 1, 1, 0, 0);   // R10 AHP all ones
        send(32'h00007C01, 0, 1, 1, 0);   // R10 no invalid
        send(32'h7C010000, 1, 0, 0, 1);   // R12 set beats clear
        idle(2, 0);
        for (int k = 0; k < 10; k++) begin  // R5 each leading-zero count
            send({16'h0, 6'd0, 10'(1 << k)}, 0, 0, 0, 0);
            send({16'h0, 6'b100000, 10'((1 << k) | 1)}, 0, 0, 0, 0);
        end
        for (int e = 1; e < 31; e++) begin  // R4 exponent sweep
            send({1'b0, 5'(e), 10'(e * 37), 16'h5555}, 1, 0, 0, 0);
        end
        idle(3, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule